// File: doc/BRIEF.md
# Real-Time Clock Update Controller

This block keeps wall-clock time (seconds, minutes, hours) and a simple calendar (day of month, month, two-digit year). A one-cycle pulse on `tick_1hz` starts an update cycle. The cycle lasts `UPD_CYCLES` clock cycles. When it completes, every time and calendar byte moves forward by one second, with all carries. The bytes are held in the format that software selects: packed BCD or plain binary, and a 12-hour or a 24-hour clock. In 12-hour mode the top bit of the hour byte marks PM.

The block also holds the configuration byte: update inhibit, three interrupt enables, data mode, hour format and two legacy bits. Each completed update compares the new time against three alarm bytes. Three sticky flags record an alarm match, the end of an update and a periodic tick whose rate is programmable. Each flag, gated by its own enable, drives one registered interrupt line. Software reaches everything through a byte-wide indexed port. A read of the flag byte returns the flags and clears them.

Two reset inputs clear separate groups of state. One models the clock-domain reset and the other models the resume-domain reset. The inhibit, data-mode, hour-format and daylight bits are cleared by neither.

Top module: `rtc_ctrl`

## Requirements
- R1: With the inhibit bit (config bit 0) at 0, a `tick_1hz` pulse starts an update that commits `UPD_CYCLES` cycles later and advances the time by exactly one second. A tick that arrives while an update is running is ignored.
- R2: While the inhibit bit is 1, ticks start no update. Setting the bit during a running update aborts it, so no time byte changes and the update-ended flag is not set.
- R3: Config bit 1 selects the data mode: 0 gives packed BCD, so seconds 0x09 becomes 0x10; 1 gives binary, so seconds 0x09 becomes 0x0A. Seconds wrap from 59 to 0 with a carry into minutes, and minutes wrap the same way into hours.
- R4: Config bit 2 at 1 selects 24-hour mode, where hour 23 wraps to 0 and advances the day. At 0 it selects 12-hour mode, where hour byte bit 7 is PM and the hours run 12, 1, ..., 11. The step from 11 to 12 toggles PM, and the step from 11 PM to 12 AM advances the day.
- R5: The day wraps to 1 after the last day of the month: 30 days for months 4, 6, 9 and 11; 29 for month 2 when the year is divisible by 4, otherwise 28; 31 for all other months. Month 12 wraps to 1 and advances the year, and year 99 wraps to 0.
- R6: When an update commits, the alarm flag (flag bit 0) is set if each alarm byte (seconds at index 6, minutes at 7, hours at 8) either equals the new byte or has bits 7:6 both set (don't-care).
- R7: Every committed update sets the update-ended flag (flag bit 1).
- R8: A nonzero rate field `r` (index 9, bits 3:0) sets the periodic flag (flag bit 2) every `PER_BASE << (r-1)` clock cycles. Rate 0 stops the periodic flag.
- R9: `irq` is registered and is high when a flag is set together with its enable: alarm with config bit 3, update-ended with bit 4, periodic with bit 5. A read of the flag byte (index 11) returns {irq, 0000, periodic, update-ended, alarm} and clears all three flags. A flag that is set in the same cycle as that read survives the clear.
- R10: `rst_resume` clears config bits 4, 5 and 6 and the flags. `rst_rtc` clears config bit 3, the flags, the alarm bytes and the rate, and sets the time to 00:00:00, day 1, month 1, year 0. Config bits 0, 1, 2 and 7 keep their value through both resets.
- R11: Config bits 6 and 7 read back as written and do not affect timekeeping.
- R12: Indices 0 to 5 hold seconds, minutes, hours, day, month and year. A host write to one of them is stored even while updates run, and the next update advances from the written value. If the write and a commit fall in the same cycle, the host write wins for that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_rtc | input | 1 | Synchronous clock-domain reset, active high |
| rst_resume | input | 1 | Synchronous resume-domain reset, active high |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; `rdata` updates on the next edge |
| addr | input | 4 | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Combined interrupt, registered |

## Verification
The collision that matters most is a read of the flag byte landing on the same edge as an update commit: the read clears the flags while the commit sets the update-ended flag. The bench starts an update and counts out exactly `UPD_CYCLES` edges, so the flag read is sampled on the commit edge. It then expects the read to return the old, empty flags and a second read to show the update-ended flag and the raised interrupt. The abort path is provoked by the same kind of counting, with the inhibit write placed two edges into the update, and is judged by unchanged time bytes and an empty flag byte.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  // time byte slots, also their register indices
  localparam int T_SEC  = 0;
  localparam int T_MIN  = 1;
  localparam int T_HOUR = 2;
  localparam int T_DAY  = 3;
  localparam int T_MON  = 4;
  localparam int T_YEAR = 5;
  localparam int NT     = 6;
  localparam int NA     = 3;  // alarm bytes follow the time bytes

  localparam logic [3:0] A_RATE = 4'd9;
  localparam logic [3:0] A_CFG  = 4'd10;
  localparam logic [3:0] A_FLAG = 4'd11;

  // configuration byte layout
  localparam int CB_INH = 0;
  localparam int CB_BIN = 1;
  localparam int CB_H24 = 2;
  localparam int CB_AE  = 3;
  localparam int CB_UE  = 4;
  localparam int CB_PE  = 5;
  localparam int CB_LEG = 6;
  localparam int CB_DST = 7;

  function automatic logic [6:0] to_bin(input logic [7:0] v, input logic bin);
    logic [6:0] hi, lo;
    hi = {3'b000, v[7:4]};
    lo = {3'b000, v[3:0]};
    return bin ? v[6:0] : (hi * 7'd10) + lo;
  endfunction

  function automatic logic [7:0] from_bin(input logic [6:0] v, input logic bin);
    return bin ? {1'b0, v} : {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  function automatic logic alm_match(input logic [7:0] a, input logic [7:0] v);
    return (a[7:6] == 2'b11) || (a == v);
  endfunction

endpackage

// File: rtl/rtc_update_seq.sv
module rtc_update_seq #(
  parameter int UPD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic inhibit,
  output logic commit
);
  localparam int CW = (UPD_CYCLES > 1) ? $clog2(UPD_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(UPD_CYCLES - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (inhibit || cnt_q == LAST) busy_q <= 1'b0;  // abort or finish
      else                          cnt_q  <= cnt_q + CW'(1);
    end else if (tick && !inhibit) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end
  end

  assign commit = busy_q && !inhibit && (cnt_q == LAST);

  // R1: one commit per update
  a_r1_commit_single: assert property (@(posedge clk) disable iff (rst)
    commit |=> !commit);

endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic #(
  parameter int PER_BASE = 8,
  parameter int RATE_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int CW = $clog2(PER_BASE) + (1 << RATE_W) - 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] period;

  always_comb period = CW'(PER_BASE) << (rate - RATE_W'(1));

  assign tick = (rate != '0) && (cnt_q >= period - CW'(1));

  always_ff @(posedge clk) begin
    if (rst || rate == '0) cnt_q <= '0;
    else if (tick)         cnt_q <= '0;
    else                   cnt_q <= cnt_q + CW'(1);
  end

  // R8: periodic events never come back to back
  a_r8_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

endmodule

// File: rtl/rtc_next_time.sv
module rtc_next_time
  import rtc_pkg::*;
(
  input  logic [NT-1:0][7:0] now_t,
  input  logic               bin,
  input  logic               h24,
  output logic [NT-1:0][7:0] nxt_t
);
  logic [6:0] s, m, hv, d, mo, y, dim;
  logic [6:0] ns, nm, nh, nd, nmo, ny;
  logic       pm, npm, c_min, c_hr, c_day, c_mon;
  logic [7:0] hb;

  always_comb begin
    s  = to_bin(now_t[T_SEC], bin);
    m  = to_bin(now_t[T_MIN], bin);
    hv = to_bin(h24 ? now_t[T_HOUR] : {1'b0, now_t[T_HOUR][6:0]}, bin);
    d  = to_bin(now_t[T_DAY], bin);
    mo = to_bin(now_t[T_MON], bin);
    y  = to_bin(now_t[T_YEAR], bin);
    pm = now_t[T_HOUR][7] && !h24;

    unique case (mo)
      7'd2:                     dim = (y[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:  dim = 7'd30;
      default:                  dim = 7'd31;
    endcase

    nm = m; nh = hv; npm = pm; nd = d; nmo = mo; ny = y;
    c_day = 1'b0; c_mon = 1'b0;

    c_min = (s >= 7'd59);
    ns    = c_min ? 7'd0 : s + 7'd1;
    c_hr  = c_min && (m >= 7'd59);
    if (c_min) nm = (m >= 7'd59) ? 7'd0 : m + 7'd1;

    if (c_hr) begin
      if (h24) begin
        c_day = (hv >= 7'd23);
        nh    = c_day ? 7'd0 : hv + 7'd1;
      end else begin
        c_day = (hv == 7'd11) && pm;
        if (hv == 7'd11) begin
          nh  = 7'd12;
          npm = !pm;
        end else if (hv >= 7'd12) nh = 7'd1;
        else                      nh = hv + 7'd1;
      end
    end

    if (c_day) begin
      if (d >= dim) begin
        nd    = 7'd1;
        c_mon = 1'b1;
      end else nd = d + 7'd1;
    end

    if (c_mon) begin
      if (mo >= 7'd12) begin
        nmo = 7'd1;
        ny  = (y >= 7'd99) ? 7'd0 : y + 7'd1;
      end else nmo = mo + 7'd1;
    end

    hb            = from_bin(nh, bin);
    nxt_t[T_SEC]  = from_bin(ns, bin);
    nxt_t[T_MIN]  = from_bin(nm, bin);
    nxt_t[T_HOUR] = h24 ? hb : {npm, hb[6:0]};
    nxt_t[T_DAY]  = from_bin(nd, bin);
    nxt_t[T_MON]  = from_bin(nmo, bin);
    nxt_t[T_YEAR] = from_bin(ny, bin);
  end

endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int UPD_CYCLES = 4,
  parameter int PER_BASE   = 8
) (
  input  logic       clk,
  input  logic       rst_rtc,
  input  logic       rst_resume,
  input  logic       tick_1hz,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq
);
  logic               rst_any;
  logic [NT-1:0][7:0] tm_q, nxt_t;
  logic [NA-1:0][7:0] alm_q;
  logic [3:0]         rate_q;
  logic               inh_q, bin_q, h24_q, dst_q, ae_q, ue_q, pe_q, leg_q;
  logic               af_q, uf_q, pf_q, irq_q;
  logic [7:0]         rdata_q, rd_mux;
  logic               commit, per_tick, wr_cfg, rd_clr, alarm_hit;

  assign rst_any = rst_rtc || rst_resume;
  assign wr_cfg  = wr_en && (addr == A_CFG);
  assign rd_clr  = rd_en && (addr == A_FLAG);

  rtc_update_seq #(.UPD_CYCLES(UPD_CYCLES)) u_seq (
    .clk(clk), .rst(rst_any), .tick(tick_1hz), .inhibit(inh_q), .commit(commit));

  rtc_periodic #(.PER_BASE(PER_BASE), .RATE_W(4)) u_per (
    .clk(clk), .rst(rst_any), .rate(rate_q), .tick(per_tick));

  rtc_next_time u_nxt (.now_t(tm_q), .bin(bin_q), .h24(h24_q), .nxt_t(nxt_t));

  assign alarm_hit = alm_match(alm_q[0], nxt_t[T_SEC]) &&
                     alm_match(alm_q[1], nxt_t[T_MIN]) &&
                     alm_match(alm_q[2], nxt_t[T_HOUR]);

  // time, alarm and configuration storage
  always_ff @(posedge clk) begin
    for (int i = 0; i < NT; i++) begin
      if (rst_rtc)                       tm_q[i] <= (i == T_DAY || i == T_MON) ? 8'h01 : 8'h00;
      else if (wr_en && addr == 4'(i))   tm_q[i] <= wdata;   // host write wins
      else if (commit)                   tm_q[i] <= nxt_t[i];
    end
    for (int j = 0; j < NA; j++) begin
      if (rst_rtc)                           alm_q[j] <= 8'h00;
      else if (wr_en && addr == 4'(NT + j))  alm_q[j] <= wdata;
    end
    if (rst_rtc)                            rate_q <= 4'd0;
    else if (wr_en && addr == A_RATE)       rate_q <= wdata[3:0];
    if (rst_rtc)     ae_q <= 1'b0;
    else if (wr_cfg) ae_q <= wdata[CB_AE];
    if (rst_resume) begin
      ue_q <= 1'b0; pe_q <= 1'b0; leg_q <= 1'b0;
    end else if (wr_cfg) begin
      ue_q <= wdata[CB_UE]; pe_q <= wdata[CB_PE]; leg_q <= wdata[CB_LEG];
    end
    if (wr_cfg) begin  // kept through every reset
      inh_q <= wdata[CB_INH]; bin_q <= wdata[CB_BIN];
      h24_q <= wdata[CB_H24]; dst_q <= wdata[CB_DST];
    end
  end

  // sticky flags: a set in the clearing cycle survives
  always_ff @(posedge clk) begin
    if (rst_any) begin
      af_q <= 1'b0; uf_q <= 1'b0; pf_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      af_q  <= (commit && alarm_hit) || (af_q && !rd_clr);
      uf_q  <= commit                || (uf_q && !rd_clr);
      pf_q  <= per_tick              || (pf_q && !rd_clr);
      irq_q <= (af_q && ae_q) || (uf_q && ue_q) || (pf_q && pe_q);
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    case (addr)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5: rd_mux = tm_q[addr[2:0]];
      4'd6:    rd_mux = alm_q[0];
      4'd7:    rd_mux = alm_q[1];
      4'd8:    rd_mux = alm_q[2];
      A_RATE:  rd_mux = {4'h0, rate_q};
      A_CFG:   rd_mux = {dst_q, leg_q, pe_q, ue_q, ae_q, h24_q, bin_q, inh_q};
      A_FLAG:  rd_mux = {irq_q, 4'h0, pf_q, uf_q, af_q};
      default: rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rd_en) rdata_q <= rd_mux;
  end

  assign rdata = rdata_q;
  assign irq   = irq_q;

  // R7: a commit always leaves the update-ended flag set
  a_r7_uf_after_commit: assert property (@(posedge clk) disable iff (rst_any)
    commit |=> uf_q);

  // R2: inhibited seconds only change through host writes
  a_r2_inhibit_freeze: assert property (@(posedge clk) disable iff (rst_any)
    (inh_q && !wr_en) |=> $stable(tm_q[T_SEC]));

  // R9: a flag read with no concurrent event leaves every flag clear
  a_r9_read_clears: assert property (@(posedge clk) disable iff (rst_any)
    (rd_clr && !commit && !per_tick) |=> (!af_q && !uf_q && !pf_q));

  // R6: the alarm flag rises only on a commit
  a_r6_alarm_on_commit: assert property (@(posedge clk) disable iff (rst_any)
    $rose(af_q) |-> $past(commit));

endmodule

// File: tb/tb_rtc_ctrl.sv
module tb_rtc_ctrl;
  localparam int UPD = 4;
  localparam int PB  = 8;

  logic       clk = 1'b0;
  logic       rst_rtc, rst_resume, tick_1hz, wr_en, rd_en;
  logic [3:0] addr;
  logic [7:0] wdata, rdata, rd_val;
  logic       irq;
  int         checks = 0, errors = 0;
  bit         done = 0;

  always #10 clk = ~clk;  // 50 MHz

  rtc_ctrl #(.UPD_CYCLES(UPD), .PER_BASE(PB)) dut (
    .clk(clk), .rst_rtc(rst_rtc), .rst_resume(rst_resume), .tick_1hz(tick_1hz),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; rd_val = rdata;
  endtask

  task automatic expect_reg(input string tag, input logic [3:0] a, input logic [7:0] e);
    rd(a); check(tag, rd_val, e);
  endtask

  task automatic tick_once();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
    repeat (UPD + 2) @(negedge clk);
  endtask

  task automatic set_time(input logic [7:0] cfg, input logic [7:0] s, m, h, d, mo, y);
    wr(4'd10, cfg | 8'h01);
    wr(4'd0, s); wr(4'd1, m); wr(4'd2, h); wr(4'd3, d); wr(4'd4, mo); wr(4'd5, y);
    wr(4'd10, cfg);
  endtask

  task automatic expect_time(input string tag, input logic [7:0] s, m, h, d, mo, y);
    expect_reg({tag, " sec"}, 4'd0, s);
    expect_reg({tag, " min"}, 4'd1, m);
    expect_reg({tag, " hour"}, 4'd2, h);
    expect_reg({tag, " day"}, 4'd3, d);
    expect_reg({tag, " month"}, 4'd4, mo);
    expect_reg({tag, " year"}, 4'd5, y);
  endtask

  task automatic t_reset();
    rst_rtc = 1'b1; rst_resume = 1'b1;
    repeat (2) @(negedge clk);
    wr(4'd10, 8'hCE);  // bits 7,2,1 must survive, 6 and 3 are cleared
    repeat (2) @(negedge clk);
    rst_rtc = 1'b0; rst_resume = 1'b0;
    expect_reg("R10 config after reset", 4'd10, 8'h86);
    expect_time("R10 time after reset", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);
    expect_reg("R10 flags after reset", 4'd11, 8'h00);
    expect_reg("R10 rate after reset", 4'd9, 8'h00);
    check("R10 irq after reset", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_split_resets();
    wr(4'd10, 8'hFE);
    @(negedge clk); rst_resume = 1'b1;
    @(negedge clk); rst_resume = 1'b0;
    expect_reg("R10 resume reset clears 6,5,4", 4'd10, 8'h8E);
    wr(4'd0, 8'h22);
    @(negedge clk); rst_rtc = 1'b1;
    @(negedge clk); rst_rtc = 1'b0;
    expect_reg("R10 rtc reset clears 3", 4'd10, 8'h86);
    expect_reg("R10 rtc reset clears seconds", 4'd0, 8'h00);
  endtask

  task automatic t_basic();
    set_time(8'h04, 8'h56, 8'h34, 8'h12, 8'h10, 8'h06, 8'h21);
    tick_once();
    expect_time("R1 one tick", 8'h57, 8'h34, 8'h12, 8'h10, 8'h06, 8'h21);
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
    @(negedge clk); tick_1hz = 1'b1;  // arrives mid-update
    @(negedge clk); tick_1hz = 1'b0;
    repeat (UPD + 2) @(negedge clk);
    expect_reg("R1 tick during update ignored", 4'd0, 8'h58);
  endtask

  task automatic t_formats();
    set_time(8'h04, 8'h09, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);
    tick_once();
    expect_reg("R3 bcd 09 to 10", 4'd0, 8'h10);
    set_time(8'h06, 8'h09, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);
    tick_once();
    expect_reg("R3 binary 09 to 0A", 4'd0, 8'h0A);
    set_time(8'h06, 8'h3B, 8'h05, 8'h07, 8'h01, 8'h01, 8'h00);
    tick_once();
    expect_time("R3 binary minute carry", 8'h00, 8'h06, 8'h07, 8'h01, 8'h01, 8'h00);
  endtask

  task automatic t_hours();
    set_time(8'h00, 8'h59, 8'h59, 8'h11, 8'h05, 8'h03, 8'h24);
    tick_once();
    expect_time("R4 11 AM to 12 PM", 8'h00, 8'h00, 8'h92, 8'h05, 8'h03, 8'h24);
    set_time(8'h00, 8'h59, 8'h59, 8'h92, 8'h05, 8'h03, 8'h24);
    tick_once();
    expect_reg("R4 12 PM to 1 PM", 4'd2, 8'h81);
    set_time(8'h00, 8'h59, 8'h59, 8'h91, 8'h05, 8'h03, 8'h24);
    tick_once();
    expect_time("R4 11 PM to 12 AM", 8'h00, 8'h00, 8'h12, 8'h06, 8'h03, 8'h24);
    set_time(8'h06, 8'h3B, 8'h3B, 8'h17, 8'h0A, 8'h07, 8'h05);
    tick_once();
    expect_time("R4 24h wrap", 8'h00, 8'h00, 8'h00, 8'h0B, 8'h07, 8'h05);
  endtask

  task automatic t_calendar();
    set_time(8'h04, 8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23);
    tick_once();
    expect_time("R5 feb 28 common year", 8'h00, 8'h00, 8'h00, 8'h01, 8'h03, 8'h23);
    set_time(8'h06, 8'h3B, 8'h3B, 8'h17, 8'h1C, 8'h02, 8'h18);
    tick_once();
    expect_reg("R5 feb 28 leap year", 4'd3, 8'h1D);
    set_time(8'h06, 8'h3B, 8'h3B, 8'h17, 8'h1D, 8'h02, 8'h18);
    tick_once();
    expect_time("R5 feb 29 leap year", 8'h00, 8'h00, 8'h00, 8'h01, 8'h03, 8'h18);
    set_time(8'h06, 8'h3B, 8'h3B, 8'h17, 8'h1E, 8'h04, 8'h0A);
    tick_once();
    expect_reg("R5 april 30 day", 4'd3, 8'h01);
    expect_reg("R5 april 30 month", 4'd4, 8'h05);
    set_time(8'h04, 8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99);
    tick_once();
    expect_time("R5 year wrap", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);
  endtask

  task automatic t_alarm();
    set_time(8'h0C, 8'h30, 8'h20, 8'h10, 8'h01, 8'h01, 8'h00);
    wr(4'd6, 8'h31); wr(4'd7, 8'hC0); wr(4'd8, 8'hFF);
    rd(4'd11);
    tick_once();
    expect_reg("R6 R7 alarm with don't-cares", 4'd11, 8'h83);
    wr(4'd6, 8'h35);
    tick_once();
    expect_reg("R6 alarm mismatch, R7 update flag", 4'd11, 8'h02);
    wr(4'd6, 8'hC0); wr(4'd7, 8'h20); wr(4'd8, 8'h10);
    tick_once();
    expect_reg("R6 exact minute and hour match", 4'd11, 8'h83);
    wr(4'd6, 8'h3F); wr(4'd7, 8'h3F); wr(4'd8, 8'h3F);
    wr(4'd10, 8'h04);
    rd(4'd11);
  endtask

  task automatic t_inhibit();
    set_time(8'h05, 8'h10, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05);
    rd(4'd11);
    tick_once();
    expect_reg("R2 inhibited tick seconds", 4'd0, 8'h10);
    expect_reg("R2 inhibited tick flags", 4'd11, 8'h00);
    wr(4'd10, 8'h04);
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
    wr(4'd10, 8'h05);  // sampled two edges into the update
    wr(4'd10, 8'h04);
    repeat (UPD + 2) @(negedge clk);
    expect_reg("R2 aborted update seconds", 4'd0, 8'h10);
    expect_reg("R2 aborted update flags", 4'd11, 8'h00);
  endtask

  task automatic t_periodic();
    wr(4'd10, 8'h24);
    wr(4'd9, 8'h00);
    rd(4'd11);
    repeat (30) @(negedge clk);
    expect_reg("R8 rate zero stops flag", 4'd11, 8'h00);
    wr(4'd9, 8'h01);
    repeat (3) @(negedge clk);
    expect_reg("R8 before first period", 4'd11, 8'h00);
    repeat (6) @(negedge clk);
    expect_reg("R8 R9 after first period", 4'd11, 8'h84);
    repeat (2) @(negedge clk);
    check("R9 irq drops after clearing read", {7'd0, irq}, 8'h00);
    wr(4'd9, 8'h00);
    wr(4'd10, 8'h04);
    rd(4'd11);
  endtask

  task automatic t_collision();
    set_time(8'h14, 8'h03, 8'h02, 8'h01, 8'h01, 8'h01, 8'h00);
    rd(4'd11);
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
    repeat (UPD - 2) @(negedge clk);
    rd(4'd11);  // sampled on the commit edge
    check("R9 read on commit edge returns old flags", rd_val, 8'h00);
    expect_reg("R9 flag set on clearing edge survives", 4'd11, 8'h82);
    wr(4'd10, 8'h04);
  endtask

  task automatic t_host_write();
    wr(4'd0, 8'h40);
    expect_reg("R12 host write stored", 4'd0, 8'h40);
    tick_once();
    expect_reg("R12 update from written value", 4'd0, 8'h41);
    expect_reg("R12 minutes untouched", 4'd1, 8'h02);
  endtask

  task automatic t_legacy();
    set_time(8'hC4, 8'h29, 8'h15, 8'h08, 8'h02, 8'h02, 8'h02);
    tick_once();
    expect_time("R11 legacy bits no effect", 8'h30, 8'h15, 8'h08, 8'h02, 8'h02, 8'h02);
    expect_reg("R11 legacy bits read back", 4'd10, 8'hC4);
  endtask

  initial begin
    rst_rtc = 1'b1; rst_resume = 1'b1; tick_1hz = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; addr = 4'd0; wdata = 8'h00;
    t_reset();
    t_split_resets();
    t_basic();
    t_formats();
    t_hours();
    t_calendar();
    t_alarm();
    t_inhibit();
    t_periodic();
    t_collision();
    t_host_write();
    t_legacy();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule